// File: doc/BRIEF.md
# Flash Storage Array Emulator

This block stands in for a non-volatile flash array inside a chip, but it is built from ordinary on-chip storage. It enforces flash write rules on that storage. Reads are random access, one word at a time. A program can only clear bits: the stored word becomes the old contents ANDed with the new data. Only an erase of a whole block sets bits back to one. Program and erase are slow operations. The `busy` output stays high for a programmable number of cycles after either one is accepted, while a read returns its data on the next cycle.

The `nand_mode` input turns on a strict page discipline. Each block keeps a next-page pointer, and a program is accepted only if it targets the page that pointer names. The pointer moves on once the last word of that page has been programmed, and an erase of the block returns it to page 0. Any command that cannot be accepted leaves the array untouched and sets a sticky `err` flag.

The controller is a three-state machine. ST_IDLE accepts commands. An accepted program moves it from ST_IDLE to ST_PROG, and an accepted erase moves it from ST_IDLE to ST_ERASE. In either busy state a countdown runs, and when the countdown reaches zero the machine returns to ST_IDLE. A read never leaves ST_IDLE. The address splits into three fields, high to low: block index, page index and word offset.

Top module: `flash_array_emu`

## Requirements
- R1: After reset every address reads as all ones, `busy` is 0 and `err` is 0.
- R2: A read accepted in ST_IDLE puts the addressed word on `rd_data` at the next clock edge, and `busy` stays 0.
- R3: An accepted program stores the old word AND `wr_data`. A bit already at 0 can never return to 1 through a program.
- R4: After an accepted program, `busy` is 1 for exactly PROG_CYCLES cycles.
- R5: An accepted erase sets every word of the addressed block (address bits above the page field) to all ones. It leaves other blocks unchanged, and `busy` is 1 for exactly ERASE_CYCLES cycles.
- R6: Any command presented while `busy` is 1 is ignored and sets `err`.
- R7: Two or more of `cmd_rd`, `cmd_prog` and `cmd_erase` high in the same cycle is ignored and sets `err`, and `busy` stays 0.
- R8: With `nand_mode` = 1, a program to the page equal to the block's pointer is accepted. Programming the word at offset PAGE_WORDS-1 advances the pointer by one.
- R9: With `nand_mode` = 1, a program to any other page is rejected: memory is unchanged, `busy` stays 0 and `err` is set.
- R10: An erase returns the block's page pointer to 0.
- R11: With `nand_mode` = 0, programs are accepted at any page in any order.
- R12: Once set, `err` stays 1 until reset, and it does not block later legal commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| nand_mode | input | 1 | 1 turns on sequential page enforcement |
| cmd_rd | input | 1 | Read request |
| cmd_prog | input | 1 | Program request |
| cmd_erase | input | 1 | Block erase request |
| addr | input | ADDR_W (9) | Word address: {block, page, offset} |
| wr_data | input | WORD_W (16) | Program data |
| rd_data | output | WORD_W (16) | Read result, one cycle after the read |
| busy | output | 1 | Program or erase in progress |
| err | output | 1 | Sticky rejected-command flag |

## Verification
The assertions assume each command request is held for a single cycle and that `rst_n` is asserted before any command. They also rely on a busy run always beginning with an accepted program or erase, so every run length equals one of the two cycle parameters. The directed stimulus raises each command for exactly one cycle. It waits on `busy` before the next legal command and issues commands during a busy run only when it is testing their rejection. Each scenario starts from a fresh reset, so every scenario sees `err` rise from 0.

// File: rtl/flash_pkg.sv
package flash_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } flash_state_e;
endpackage

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
    parameter int WORDS  = 512,
    parameter int WORD_W = 16,
    localparam int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/flash_blank_map.sv
module flash_blank_map #(
    parameter int WORDS     = 512,
    parameter int BLK_WORDS = 64,
    localparam int AW       = $clog2(WORDS),
    localparam int BW       = $clog2(WORDS / BLK_WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          clr_word,
    input  logic          set_blk,
    input  logic [BW-1:0] blk,
    output logic          blank
);
    logic [WORDS-1:0] blank_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blank_q <= '1;
        end else begin
            for (int i = 0; i < WORDS; i++) begin
                if (set_blk && (i / BLK_WORDS) == int'(blk))
                    blank_q[i] <= 1'b1;
                else if (clr_word && i == int'(addr))
                    blank_q[i] <= 1'b0;
            end
        end
    end

    assign blank = blank_q[addr];
endmodule

// File: rtl/flash_page_ptr.sv
module flash_page_ptr #(
    parameter int NUM_BLKS  = 8,
    parameter int PAGES     = 4,
    localparam int BW       = $clog2(NUM_BLKS),
    localparam int PTR_W    = $clog2(PAGES) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BW-1:0]    blk,
    input  logic             adv,
    input  logic             clr,
    output logic [PTR_W-1:0] ptr
);
    logic [PTR_W-1:0] ptr_q [NUM_BLKS];

    for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ptr_q[b] <= '0;
            else if (clr && blk == BW'(b))
                ptr_q[b] <= '0;
            else if (adv && blk == BW'(b) && ptr_q[b] < PTR_W'(PAGES))
                ptr_q[b] <= ptr_q[b] + 1'b1;
        end
    end

    assign ptr = ptr_q[blk];
endmodule

// File: rtl/flash_array_emu.sv
module flash_array_emu
    import flash_pkg::*;
#(
    parameter int WORD_W       = 16,
    parameter int PAGE_WORDS   = 16,
    parameter int PAGES        = 4,
    parameter int NUM_BLKS     = 8,
    parameter int PROG_CYCLES  = 5,
    parameter int ERASE_CYCLES = 20,
    localparam int BLK_WORDS   = PAGE_WORDS * PAGES,
    localparam int WORDS       = BLK_WORDS * NUM_BLKS,
    localparam int ADDR_W      = $clog2(WORDS),
    localparam int OFS_W       = $clog2(PAGE_WORDS),
    localparam int PG_W        = $clog2(PAGES),
    localparam int BLK_W       = $clog2(NUM_BLKS),
    localparam int PTR_W       = PG_W + 1,
    localparam int MAX_CYC     = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES,
    localparam int CNT_W       = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nand_mode,
    input  logic              cmd_rd,
    input  logic              cmd_prog,
    input  logic              cmd_erase,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    output logic              busy,
    output logic              err
);
    flash_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    logic [OFS_W-1:0] a_ofs;
    logic [PG_W-1:0]  a_page;
    logic [BLK_W-1:0] a_blk;
    assign a_ofs  = addr[OFS_W-1:0];
    assign a_page = addr[OFS_W +: PG_W];
    assign a_blk  = addr[ADDR_W-1 -: BLK_W];

    logic [WORD_W-1:0] cell_rdata, old_word, new_word;
    logic              blank;
    logic [PTR_W-1:0]  ptr;

    logic [1:0] n_cmd;
    logic       idle, single, page_ok;
    logic       acc_rd, acc_pg, acc_er, rej_pg, conflict;

    always_comb begin
        n_cmd    = 2'(cmd_rd) + 2'(cmd_prog) + 2'(cmd_erase);
        idle     = (state_q == ST_IDLE);
        single   = idle && (n_cmd == 2'd1);
        page_ok  = !nand_mode || ({1'b0, a_page} == ptr);
        acc_rd   = single && cmd_rd;
        acc_pg   = single && cmd_prog && page_ok;
        acc_er   = single && cmd_erase;
        rej_pg   = single && cmd_prog && !page_ok;
        conflict = (n_cmd != 2'd0) && (!idle || n_cmd > 2'd1);
        old_word = blank ? '1 : cell_rdata;
        new_word = old_word & wr_data;
    end

    flash_cell_array #(.WORDS(WORDS), .WORD_W(WORD_W)) cells_i (
        .clk   (clk),
        .we    (acc_pg),
        .addr  (addr),
        .wdata (new_word),
        .rdata (cell_rdata)
    );

    flash_blank_map #(.WORDS(WORDS), .BLK_WORDS(BLK_WORDS)) blank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .clr_word (acc_pg),
        .set_blk  (acc_er),
        .blk      (a_blk),
        .blank    (blank)
    );

    flash_page_ptr #(.NUM_BLKS(NUM_BLKS), .PAGES(PAGES)) ptr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .blk   (a_blk),
        .adv   (acc_pg && nand_mode && a_ofs == OFS_W'(PAGE_WORDS - 1)),
        .clr   (acc_er),
        .ptr   (ptr)
    );

    // Next state and countdown.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_pg) begin
                    state_d = ST_PROG;
                    cnt_d   = CNT_W'(PROG_CYCLES - 1);
                end else if (acc_er) begin
                    state_d = ST_ERASE;
                    cnt_d   = CNT_W'(ERASE_CYCLES - 1);
                end
            end
            ST_PROG, ST_ERASE: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '1;
            busy    <= 1'b0;
            err     <= 1'b0;
        end else begin
            busy <= (state_d != ST_IDLE);
            if (conflict || rej_pg) err <= 1'b1;
            if (acc_rd) rd_data <= old_word;
        end
    end
endmodule

// File: rtl/flash_array_chk.sv
module flash_array_chk #(
    parameter int PROG_CYCLES  = 5,
    parameter int ERASE_CYCLES = 20
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_rd,
    input logic cmd_prog,
    input logic cmd_erase,
    input logic busy,
    input logic err
);
    logic [15:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    // R6
    busy_cmd_flags_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && (cmd_rd || cmd_prog || cmd_erase)) |=> err);

    // R12
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R5
    erase_goes_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_erase && !cmd_rd && !cmd_prog) |=> busy);

    // R2
    read_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_rd && !cmd_prog && !cmd_erase) |=> !busy);

    // R7
    multi_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({cmd_rd, cmd_prog, cmd_erase}) > 1) |=> (err && !$rose(busy)));

    // R4
    busy_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == 16'(PROG_CYCLES) || run_len == 16'(ERASE_CYCLES)));
endmodule

bind flash_array_emu flash_array_chk #(
    .PROG_CYCLES  (PROG_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_rd    (cmd_rd),
    .cmd_prog  (cmd_prog),
    .cmd_erase (cmd_erase),
    .busy      (busy),
    .err       (err)
);

// File: tb/flash_array_emu_tb.sv
module flash_array_emu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WORD_W = 16;
    localparam int PROG_C = 5;
    localparam int ERASE_C = 20;
    localparam int ADDR_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nand_mode = 1'b0;
    logic cmd_rd = 1'b0, cmd_prog = 1'b0, cmd_erase = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic [WORD_W-1:0] rd_data;
    logic busy, err;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_array_emu #(
        .WORD_W(WORD_W), .PAGE_WORDS(16), .PAGES(4), .NUM_BLKS(8),
        .PROG_CYCLES(PROG_C), .ERASE_CYCLES(ERASE_C)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .nand_mode(nand_mode),
        .cmd_rd(cmd_rd), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data),
        .busy(busy), .err(err)
    );

    function automatic logic [ADDR_W-1:0] mk(int blk, int pg, int ofs);
        return {3'(blk), 2'(pg), 4'(ofs)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        cmd_rd = 0; cmd_prog = 0; cmd_erase = 0; nand_mode = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic issue(input bit r, input bit p, input bit e,
                         input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
        cmd_rd = r; cmd_prog = p; cmd_erase = e; addr = a; wr_data = d;
        @(negedge clk);
        cmd_rd = 0; cmd_prog = 0; cmd_erase = 0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic read_word(input logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] v);
        issue(1, 0, 0, a, '0);
        v = rd_data;
    endtask

    task automatic prog_word(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
        int n;
        issue(0, 1, 0, a, d);
        wait_idle(n);
    endtask

    task automatic t_reset();
        logic [WORD_W-1:0] v;
        do_reset();
        check(busy == 0, "R1 busy", busy, 0);
        check(err == 0, "R1 err", err, 0);
        read_word(mk(0, 0, 0), v);
        check(v == 16'hFFFF, "R1 first word", v, 16'hFFFF);
        read_word(mk(7, 3, 15), v);
        check(v == 16'hFFFF, "R1 last word", v, 16'hFFFF);
    endtask

    task automatic t_program();
        logic [WORD_W-1:0] v;
        int n;
        do_reset();
        issue(0, 1, 0, mk(1, 2, 5), 16'hF0F0);
        check(busy == 1, "R4 busy rises", busy, 1);
        wait_idle(n);
        check(n == PROG_C, "R4 busy length", n, PROG_C);
        issue(1, 0, 0, mk(1, 2, 5), '0);
        check(busy == 0, "R2 read no busy", busy, 0);
        v = rd_data;
        check(v == 16'hF0F0, "R2 read data", v, 16'hF0F0);
        prog_word(mk(1, 2, 5), 16'h3CFF);
        read_word(mk(1, 2, 5), v);
        check(v == 16'h30F0, "R3 and-merge", v, 16'h30F0);
        prog_word(mk(1, 2, 5), 16'hFFFF);
        read_word(mk(1, 2, 5), v);
        check(v == 16'h30F0, "R3 no 0 to 1", v, 16'h30F0);
        check(err == 0, "R3 no error", err, 0);
    endtask

    task automatic t_erase();
        logic [WORD_W-1:0] v;
        int n;
        do_reset();
        prog_word(mk(2, 0, 0), 16'h1234);
        prog_word(mk(2, 3, 15), 16'h0000);
        prog_word(mk(3, 0, 0), 16'hABCD);
        issue(0, 0, 1, mk(2, 1, 7), '0);
        check(busy == 1, "R5 busy rises", busy, 1);
        wait_idle(n);
        check(n == ERASE_C, "R5 busy length", n, ERASE_C);
        read_word(mk(2, 0, 0), v);
        check(v == 16'hFFFF, "R5 block start", v, 16'hFFFF);
        read_word(mk(2, 3, 15), v);
        check(v == 16'hFFFF, "R5 block end", v, 16'hFFFF);
        read_word(mk(3, 0, 0), v);
        check(v == 16'hABCD, "R5 neighbour kept", v, 16'hABCD);
    endtask

    task automatic t_busy_cmd();
        logic [WORD_W-1:0] v;
        int n;
        do_reset();
        issue(0, 1, 0, mk(4, 0, 0), 16'h00FF);
        issue(0, 1, 0, mk(4, 0, 1), 16'h0000);
        check(err == 1, "R6 err on busy cmd", err, 1);
        wait_idle(n);
        check(n == PROG_C - 1, "R6 busy not restarted", n, PROG_C - 1);
        read_word(mk(4, 0, 1), v);
        check(v == 16'hFFFF, "R6 ignored program", v, 16'hFFFF);
        repeat (5) @(negedge clk);
        check(err == 1, "R12 err sticky", err, 1);
        prog_word(mk(4, 0, 2), 16'h5555);
        read_word(mk(4, 0, 2), v);
        check(v == 16'h5555, "R12 legal after err", v, 16'h5555);
    endtask

    task automatic t_multi();
        logic [WORD_W-1:0] v;
        do_reset();
        issue(0, 1, 1, mk(5, 0, 0), 16'h0000);
        check(busy == 0, "R7 no busy", busy, 0);
        check(err == 1, "R7 err", err, 1);
        read_word(mk(5, 0, 0), v);
        check(v == 16'hFFFF, "R7 ignored", v, 16'hFFFF);
    endtask

    task automatic t_nand();
        logic [WORD_W-1:0] v;
        do_reset();
        nand_mode = 1;
        issue(0, 1, 0, mk(1, 0, 0), 16'h1111);
        check(busy == 1, "R8 page0 accepted", busy, 1);
        begin int n; wait_idle(n); end
        issue(0, 1, 0, mk(1, 1, 0), 16'h2222);
        check(busy == 0, "R9 no busy", busy, 0);
        check(err == 1, "R9 err", err, 1);
        read_word(mk(1, 1, 0), v);
        check(v == 16'hFFFF, "R9 memory unchanged", v, 16'hFFFF);
        prog_word(mk(1, 0, 15), 16'h4444);
        issue(0, 1, 0, mk(1, 1, 0), 16'h2222);
        check(busy == 1, "R8 advance to page1", busy, 1);
        begin int n; wait_idle(n); end
        read_word(mk(1, 1, 0), v);
        check(v == 16'h2222, "R8 page1 data", v, 16'h2222);
        issue(0, 0, 1, mk(1, 0, 0), '0);
        begin int n; wait_idle(n); end
        issue(0, 1, 0, mk(1, 0, 3), 16'h7777);
        check(busy == 1, "R10 page0 after erase", busy, 1);
        begin int n; wait_idle(n); end
        read_word(mk(1, 0, 3), v);
        check(v == 16'h7777, "R10 data", v, 16'h7777);
    endtask

    task automatic t_nor();
        logic [WORD_W-1:0] v;
        do_reset();
        nand_mode = 0;
        prog_word(mk(6, 3, 2), 16'h0F0F);
        prog_word(mk(6, 1, 9), 16'h00F0);
        read_word(mk(6, 3, 2), v);
        check(v == 16'h0F0F, "R11 late page", v, 16'h0F0F);
        read_word(mk(6, 1, 9), v);
        check(v == 16'h00F0, "R11 earlier page", v, 16'h00F0);
        check(err == 0, "R11 no err", err, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_program();
                t_erase();
                t_busy_cmd();
                t_multi();
                t_nand();
                t_nor();
            end
            begin
                repeat (50000) @(negedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule